// File: doc/BRIEF.md
# AXI4-Lite Scratch Register Block with Gated Status LEDs

This block is a small AXI4-Lite slave. It holds one 32-bit read/write scratch word and exposes a 16-bit read-only view of the low half of that word. The same low half, masked bit by bit by a 16-bit switch input, drives a 16-bit status LED output. A host can therefore write a pattern, read it back, and see the pattern on the LEDs, limited to the bits the switches enable.

The write side runs a four-state machine. WR_IDLE accepts an address and data together or either one alone. WR_GOT_ADDR holds a stored address and waits for data. WR_GOT_DATA holds stored data and waits for an address. WR_RESP presents the response until the master takes it. The transitions are IDLE→RESP (both arrive together), IDLE→GOT_ADDR, IDLE→GOT_DATA, GOT_ADDR→RESP, GOT_DATA→RESP and RESP→IDLE. The write commits to the register on the edge that completes the address/data pair. The read side has two states. RD_IDLE accepts an address and captures the decoded word (IDLE→RESP). RD_RESP holds that word until it is taken (RESP→IDLE).

Top module: `axil_led_regblk`

## Requirements
- R1: A write to byte address 0x500 (the whole address must match) stores into the 32-bit scratch word. The word is cleared to zero by reset.
- R2: A read of 0x500 returns the scratch word with its bytes in reverse order: stored bits 7:0 appear in bits 31:24 and stored bits 31:24 appear in bits 7:0.
- R3: A read of 0x504 returns scratch bits 15:0 in bits 15:0 and zero in bits 31:16. A write to 0x504 leaves the scratch word unchanged and still gets response 2'b00 (OKAY).
- R4: The LED output always equals scratch bits 15:0 ANDed bit by bit with the switch input.
- R5: A read of any other address returns 0xDEADBEEF with OKAY. A write to any other address changes nothing and gets OKAY.
- R6: Write address and write data may arrive together, address first or data first. No response is raised before both are accepted, and exactly one response follows each write.
- R7: On 0x500, write strobe bit n enables byte n (bits 8n+7:8n). Bytes whose strobe is low keep their old value.
- R8: During and after reset the LED output is zero and neither response valid is high.
- R9: While read valid is high and read ready is low, read data, read response and read valid hold steady. Write response valid holds until write response ready is seen.
- R10: When a read address is accepted on the same edge that a write to the scratch word commits, the read returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_awaddr | input | 12 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 12 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read valid |
| s_rready | input | 1 | Read ready |
| sw_mask | input | 16 | Switch input that masks the LEDs |
| led_out | output | 16 | Gated status LED output |

## Verification
A write commit to the scratch word and the capture of read data can happen on the same clock edge, because the two channel machines run independently. The bench provokes this by raising write address, write data and read address in the same cycle, all aimed at 0x500. It requires the returned word to be the byte-reversed value from before the write. A follow-up read must then show the new value.

// File: rtl/regblk_pkg.sv
package regblk_pkg;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_GOT_ADDR,
        WR_GOT_DATA,
        WR_RESP
    } wr_state_e;

    typedef enum logic {
        RD_IDLE,
        RD_RESP
    } rd_state_e;

    localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/axil_wr_ctrl.sv
module axil_wr_ctrl
    import regblk_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    output logic              commit,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [DATA_W-1:0] commit_data,
    output logic [STRB_W-1:0] commit_strb
);

    wr_state_e         state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [STRB_W-1:0] strb_q;
    logic              aw_fire, w_fire;

    assign aw_fire = awvalid && awready;
    assign w_fire  = wvalid && wready;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WR_IDLE;
        else        state_q <= state_d;
    end

    // captured halves of a split write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            strb_q <= '0;
        end else begin
            if (aw_fire) addr_q <= awaddr;
            if (w_fire) begin
                data_q <= wdata;
                strb_q <= wstrb;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_IDLE: begin
                if (aw_fire && w_fire) state_d = WR_RESP;
                else if (aw_fire)      state_d = WR_GOT_ADDR;
                else if (w_fire)       state_d = WR_GOT_DATA;
            end
            WR_GOT_ADDR: if (w_fire)  state_d = WR_RESP;
            WR_GOT_DATA: if (aw_fire) state_d = WR_RESP;
            WR_RESP:     if (bready)  state_d = WR_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        awready     = (state_q == WR_IDLE) || (state_q == WR_GOT_DATA);
        wready      = (state_q == WR_IDLE) || (state_q == WR_GOT_ADDR);
        bvalid      = (state_q == WR_RESP);
        bresp       = RESP_OKAY;
        commit      = ((state_q == WR_IDLE) && awvalid && wvalid) ||
                      ((state_q == WR_GOT_ADDR) && wvalid) ||
                      ((state_q == WR_GOT_DATA) && awvalid);
        commit_addr = (state_q == WR_GOT_ADDR) ? addr_q : awaddr;
        commit_data = (state_q == WR_GOT_DATA) ? data_q : wdata;
        commit_strb = (state_q == WR_GOT_DATA) ? strb_q : wstrb;
    end

    // R6: a response only ever follows a commit
    p_resp_after_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bvalid) |-> $past(commit));

    // R6: no new address accepted while a response is outstanding
    p_no_accept_in_resp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid |-> !awready && !wready);

    // R9: response held until taken
    p_bvalid_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid && !bready |=> bvalid);

endmodule

// File: rtl/axil_rd_ctrl.sv
module axil_rd_ctrl
    import regblk_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready,
    output logic [ADDR_W-1:0] lookup_addr,
    input  logic [DATA_W-1:0] lookup_word
);

    rd_state_e         state_q, state_d;
    logic [DATA_W-1:0] rdata_q;
    logic              ar_fire;

    assign ar_fire = arvalid && arready;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (ar_fire) rdata_q <= lookup_word;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (arvalid) state_d = RD_RESP;
            RD_RESP: if (rready)  state_d = RD_IDLE;
        endcase
    end

    always_comb begin
        arready     = (state_q == RD_IDLE);
        rvalid      = (state_q == RD_RESP);
        rresp       = RESP_OKAY;
        rdata       = rdata_q;
        lookup_addr = araddr;
    end

    // R9: data and valid held while the master stalls
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid && !rready |=> rvalid && $stable(rdata));

    // read data only appears after an accepted address
    p_rvalid_after_ar_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rvalid) |-> $past(arvalid && arready));

endmodule

// File: rtl/regblk_regs.sv
module regblk_regs #(
    parameter int              ADDR_W       = 12,
    parameter int              DATA_W       = 32,
    parameter int              LED_W        = 16,
    parameter logic [ADDR_W-1:0] SCRATCH_OFS  = 12'h500,
    parameter logic [ADDR_W-1:0] SHADOW_OFS   = 12'h504,
    parameter logic [DATA_W-1:0] UNMAPPED_VAL = 32'hDEADBEEF,
    localparam int             STRB_W       = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [STRB_W-1:0] wr_strb,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word,
    input  logic [LED_W-1:0]  sw_mask,
    output logic [LED_W-1:0]  led_out
);

    logic [DATA_W-1:0] scratch_q;
    logic [DATA_W-1:0] scratch_swapped;
    logic [LED_W-1:0]  shadow;
    logic              wr_scratch_hit;

    assign wr_scratch_hit = wr_en && (wr_addr == SCRATCH_OFS);
    assign shadow         = scratch_q[LED_W-1:0];

    // per-byte strobed storage
    for (genvar b = 0; b < STRB_W; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n)
                scratch_q[8*b +: 8] <= 8'h00;
            else if (wr_scratch_hit && wr_strb[b])
                scratch_q[8*b +: 8] <= wr_data[8*b +: 8];
        end
        assign scratch_swapped[8*(STRB_W-1-b) +: 8] = scratch_q[8*b +: 8];
    end

    always_comb begin
        if (rd_addr == SCRATCH_OFS)
            rd_word = scratch_swapped;
        else if (rd_addr == SHADOW_OFS)
            rd_word = {{(DATA_W-LED_W){1'b0}}, shadow};
        else
            rd_word = UNMAPPED_VAL;
    end

    assign led_out = shadow & sw_mask;

    // R1: a full-strobe write lands in the scratch word
    p_scratch_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_scratch_hit && (wr_strb == {STRB_W{1'b1}}) |=> scratch_q == $past(wr_data));

    // R3 / R5: writes elsewhere never disturb the scratch word
    p_other_write_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_addr != SCRATCH_OFS) |=> $stable(scratch_q));

endmodule

// File: rtl/axil_led_regblk.sv
module axil_led_regblk #(
    parameter int                ADDR_W       = 12,
    parameter int                DATA_W       = 32,
    parameter int                LED_W        = 16,
    parameter logic [ADDR_W-1:0] SCRATCH_OFS  = 12'h500,
    parameter logic [ADDR_W-1:0] SHADOW_OFS   = 12'h504,
    parameter logic [DATA_W-1:0] UNMAPPED_VAL = 32'hDEADBEEF,
    localparam int               STRB_W       = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [STRB_W-1:0] s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    input  logic [LED_W-1:0]  sw_mask,
    output logic [LED_W-1:0]  led_out
);

    logic              commit;
    logic [ADDR_W-1:0] commit_addr;
    logic [DATA_W-1:0] commit_data;
    logic [STRB_W-1:0] commit_strb;
    logic [ADDR_W-1:0] lookup_addr;
    logic [DATA_W-1:0] lookup_word;

    axil_wr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
        .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
        .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
        .commit(commit), .commit_addr(commit_addr),
        .commit_data(commit_data), .commit_strb(commit_strb)
    );

    axil_rd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
        .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
        .lookup_addr(lookup_addr), .lookup_word(lookup_word)
    );

    regblk_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LED_W(LED_W),
        .SCRATCH_OFS(SCRATCH_OFS), .SHADOW_OFS(SHADOW_OFS),
        .UNMAPPED_VAL(UNMAPPED_VAL)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(commit), .wr_addr(commit_addr), .wr_data(commit_data),
        .wr_strb(commit_strb), .rd_addr(lookup_addr), .rd_word(lookup_word),
        .sw_mask(sw_mask), .led_out(led_out)
    );

    // R8: quiet outputs straight after reset
    p_reset_quiet_r8: assert property (@(posedge clk)
        !rst_n |=> led_out == '0 && !s_bvalid && !s_rvalid);

endmodule

// File: tb/axil_led_regblk_bench.sv
`timescale 1ns/100ps
module axil_led_regblk_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] awaddr = '0;
    logic        awvalid = 1'b0;
    logic        awready;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        wvalid = 1'b0;
    logic        wready;
    logic [1:0]  bresp;
    logic        bvalid;
    logic        bready = 1'b0;
    logic [11:0] araddr = '0;
    logic        arvalid = 1'b0;
    logic        arready;
    logic [31:0] rdata;
    logic [1:0]  rresp;
    logic        rvalid;
    logic        rready = 1'b0;
    logic [15:0] sw = '0;
    logic [15:0] led;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model = '0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    axil_led_regblk u_axil_led_regblk (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
        .sw_mask(sw), .led_out(led)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [11:0] a);
        if (a == 12'h500) return {model[7:0], model[15:8], model[23:16], model[31:24]};
        if (a == 12'h504) return {16'h0, model[15:0]};
        return 32'hDEADBEEF;
    endfunction

    function automatic void model_write(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
        if (a == 12'h500)
            for (int b = 0; b < 4; b++) if (s[b]) model[8*b +: 8] = d[8*b +: 8];
    endfunction

    // scoreboard monitor: compare every completed read against the queue
    always @(negedge clk) begin
        if (rst_n && rvalid && rready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected read", rdata, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rdata == e, t, rdata, e);
                chk(rresp == 2'b00, "R5 read resp OKAY", {30'h0, rresp}, 32'h0);
            end
        end
    end

    task automatic wait_b(input int bdly, input string tag);
        int n = 0;
        @(negedge clk);
        while (!bvalid && n < 20) begin @(negedge clk); n++; end
        chk(bvalid, {tag, " bvalid"}, {31'h0, bvalid}, 32'h1);
        for (int i = 0; i < bdly; i++) begin
            @(negedge clk);
            chk(bvalid, "R9 bvalid hold", {31'h0, bvalid}, 32'h1);
        end
        chk(bresp == 2'b00, {tag, " bresp"}, {30'h0, bresp}, 32'h0);
        @(posedge clk); #1 bready = 1'b1;
        @(posedge clk); #1 bready = 1'b0;
        @(negedge clk);
        chk(!bvalid, "R6 single response", {31'h0, bvalid}, 32'h0);
    endtask

    // mode 0: together, 1: address first, 2: data first
    task automatic do_write(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s,
                            input int mode, input int bdly, input string tag);
        @(negedge clk);
        awaddr = a; wdata = d; wstrb = s;
        if (mode != 2) awvalid = 1'b1;
        if (mode != 1) wvalid = 1'b1;
        @(posedge clk); #1 awvalid = 1'b0; wvalid = 1'b0;
        if (mode != 0) begin
            @(negedge clk);
            chk(!bvalid, "R6 no early response", {31'h0, bvalid}, 32'h0);
            if (mode == 1) wvalid = 1'b1; else awvalid = 1'b1;
            @(posedge clk); #1 awvalid = 1'b0; wvalid = 1'b0;
        end
        model_write(a, d, s);
        wait_b(bdly, tag);
    endtask

    task automatic wait_r(input int rdly);
        logic [31:0] held;
        int n = 0;
        @(negedge clk);
        while (!rvalid && n < 20) begin @(negedge clk); n++; end
        held = rdata;
        for (int i = 0; i < rdly; i++) begin
            @(negedge clk);
            chk(rvalid && rdata == held, "R9 read hold", rdata, held);
        end
        @(posedge clk); #1 rready = 1'b1;
        @(posedge clk); #1 rready = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a, input int rdly, input string tag);
        @(negedge clk);
        araddr = a; arvalid = 1'b1;
        exp_q.push_back(model_read(a));
        tag_q.push_back(tag);
        @(posedge clk); #1 arvalid = 1'b0;
        wait_r(rdly);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(led == 16'h0 && !bvalid && !rvalid, "R8 reset state", {16'h0, led}, 32'h0);
        rst_n = 1'b1;
        sw = 16'hFFFF;

        do_write(12'h500, 32'h11223344, 4'hF, 0, 0, "R1 write scratch");
        chk(led == 16'h3344, "R4 led full mask", {16'h0, led}, 32'h3344);
        do_read(12'h500, 0, "R2 byte reversed read");
        do_read(12'h504, 0, "R3 shadow read");

        @(negedge clk) sw = 16'h00FF;
        @(negedge clk);
        chk(led == 16'h0044, "R4 led low byte mask", {16'h0, led}, 32'h0044);
        sw = 16'hF0F0;
        @(negedge clk);
        chk(led == 16'h3040, "R4 led nibble mask", {16'h0, led}, 32'h3040);
        sw = 16'hFFFF;

        do_write(12'h504, 32'hFFFFFFFF, 4'hF, 1, 0, "R3 shadow write OKAY");
        do_read(12'h500, 0, "R3 shadow write ignored");

        do_write(12'h500, 32'hAABBCCDD, 4'h5, 2, 0, "R7 strobed write");
        do_read(12'h500, 0, "R7 strobed bytes");
        do_read(12'h504, 0, "R7 shadow after strobe");

        do_write(12'h508, 32'h00000000, 4'hF, 0, 0, "R5 unmapped write OKAY");
        do_read(12'h508, 0, "R5 unmapped read");
        do_read(12'h500, 0, "R5 unmapped write no effect");
        do_read(12'h501, 0, "R5 misaligned is unmapped");

        do_write(12'h500, 32'hCAFE0001, 4'hF, 1, 3, "R9 delayed bready");
        do_read(12'h500, 4, "R9 delayed rready");

        // R10: write commit and read capture on the same edge
        @(negedge clk);
        awaddr = 12'h500; wdata = 32'h01020304; wstrb = 4'hF;
        awvalid = 1'b1; wvalid = 1'b1;
        araddr = 12'h500; arvalid = 1'b1;
        exp_q.push_back(model_read(12'h500));
        tag_q.push_back("R10 read sees old value");
        @(posedge clk); #1 awvalid = 1'b0; wvalid = 1'b0; arvalid = 1'b0;
        model_write(12'h500, 32'h01020304, 4'hF);
        wait_r(0);
        wait_b(0, "R10 write response");
        do_read(12'h500, 0, "R10 read sees new value");

        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        model = '0;
        chk(led == 16'h0, "R8 led zero after reset", {16'h0, led}, 32'h0);
        do_read(12'h500, 0, "R1 scratch zero after reset");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R9 all reads returned", exp_q.size(), 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule